// File: doc/BRIEF.md
# Supply Brownout Monitor Controller

This block is the digital side of a supply brownout detector. Two groups of analog comparators drive it. Each group has one flag per threshold level, and a flag goes high while the supply is below that level. One group serves the interrupt function and the other serves the forced-reset function. Every flag passes through a two-flop synchronizer and then a glitch filter. The filter changes the internal condition only after the synchronized flag has differed from it for `FILT_LEN` consecutive clocks.

Software writes a control register to choose one interrupt level and one reset level, and each path has its own enable bit. The interrupt output follows the filtered flag of the chosen level whenever the interrupt path is enabled. A status register always shows the live filtered level, whether or not the interrupt is enabled. It also shows a latched "brownout seen" bit, which software clears by writing 1 to it.

A small state machine makes the reset request sticky:

- In `TRIP_ARMED`, it moves to `TRIP_HELD` when the reset path is enabled and the filtered flag of the chosen reset level is high. The level it tripped on is captured at that point.
- In `TRIP_HELD`, it returns to `TRIP_ARMED` only when the filtered flag of the captured level goes low. Later changes to the enable bit or to the select field do not affect it.

Top module: `bod_monitor`

## Requirements
- R1: After reset, CTRL reads 0x80 (reset path enabled at level 0, interrupt disabled), STATUS reads 0x00, and `irq_o` and `rst_req_o` are low.
- R2: CTRL (address 0) holds these fields: `irq_sel` in bits 1:0, `irq_en` in bit 3, `rst_sel` in bits 5:4 and `rst_en` in bit 7. All other bits read 0, and any address other than 0 or 1 reads 0.
- R3: A comparator flag that is set at the inputs shows at `irq_o` after exactly `FILT_LEN`+2 rising edges: 2 for the synchronizer and `FILT_LEN` for the filter. A pulse lasting fewer than `FILT_LEN` clocks never changes the filtered level.
- R4: `irq_o` is high exactly when `irq_en` is 1 and the filtered interrupt flag selected by `irq_sel` is high.
- R5: STATUS bit 0 shows the filtered interrupt flag selected by `irq_sel`, whatever the value of `irq_en`.
- R6: STATUS bit 1 is set on every clock in which bit 0 is high, and it stays set until software writes STATUS with bit 1 equal to 1. Writing 0 to bit 1 leaves it unchanged.
- R7: With `rst_en` set, `rst_req_o` rises one clock after the filtered reset flag selected by `rst_sel` goes high.
- R8: Once `rst_req_o` is high, it stays high while the filtered flag of the level it tripped on stays high, even if `rst_en` or `rst_sel` is changed. It falls one clock after that filtered flag falls.
- R9: With `rst_en` clear, `rst_req_o` never rises. STATUS bit 2 shows `rst_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_below_i | input | NLVL | Interrupt comparator flags, high while the supply is below the level |
| rst_below_i | input | NLVL | Reset comparator flags, high while the supply is below the level |
| reg_addr_i | input | 2 | Register address (0 CTRL, 1 STATUS) |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt line to the interrupt controller |
| rst_req_o | output | 1 | Sticky chip reset request |

## Verification
The hardest situation to reach is a reset request that has to stay asserted while software withdraws what caused it. The bench first trips the machine on a non-zero level. It then rewrites CTRL so that `rst_en` is cleared and `rst_sel` points at a quiet level. Finally it drops the tripping flag and samples the exact clock at which the request must fall. Filter rejection is covered by sweeping the pulse width across the `FILT_LEN` boundary and reading the latched status bit after each pulse.

// File: rtl/bod_pkg.sv
package bod_pkg;
    typedef enum logic {
        TRIP_ARMED = 1'b0,
        TRIP_HELD  = 1'b1
    } trip_state_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_STATUS = 2'd1;

    localparam int CTRL_IRQ_EN_BIT = 3;
    localparam int CTRL_RST_LSB    = 4;
    localparam int CTRL_RST_EN_BIT = 7;
    localparam int STAT_LIVE_BIT   = 0;
    localparam int STAT_SEEN_BIT   = 1;
    localparam int STAT_RSTQ_BIT   = 2;
endpackage

// File: rtl/bod_sync.sv
module bod_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            stage_q <= '0;
            sync_o  <= '0;
        end else begin
            stage_q <= async_i;
            sync_o  <= stage_q;
        end
    end
endmodule

// File: rtl/bod_filter.sv
module bod_filter #(
    parameter int W        = 8,
    parameter int FILT_LEN = 4
) (
    input  logic         clk,
    input  logic         rst_ni,
    input  logic [W-1:0] sync_i,
    output logic [W-1:0] filt_o
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    for (genvar g = 0; g < W; g++) begin : g_lane
        logic [CW-1:0] run_q;

        always_ff @(posedge clk or negedge rst_ni) begin
            if (!rst_ni) begin
                run_q     <= '0;
                filt_o[g] <= 1'b0;
            end else if (sync_i[g] != filt_o[g]) begin
                if (run_q == LAST) begin
                    filt_o[g] <= sync_i[g];
                    run_q     <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end

        // R3
        steady_in_chk: assert property (@(posedge clk) disable iff (!rst_ni)
            (sync_i[g] == filt_o[g]) |=> $stable(filt_o[g]));

        // R3
        flip_follows_in_chk: assert property (@(posedge clk) disable iff (!rst_ni)
            !$stable(filt_o[g]) |-> ($past(sync_i[g]) == filt_o[g]));
    end
endmodule

// File: rtl/bod_trip_fsm.sv
module bod_trip_fsm
    import bod_pkg::*;
#(
    parameter int NLVL = 4,
    localparam int SW  = $clog2(NLVL)
) (
    input  logic            clk,
    input  logic            rst_ni,
    input  logic            en_i,
    input  logic [SW-1:0]   sel_i,
    input  logic [NLVL-1:0] lvl_i,
    output logic            req_o
);
    trip_state_e state_q, state_d;
    logic [SW-1:0] hold_sel_q;

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q    <= TRIP_ARMED;
            hold_sel_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TRIP_ARMED) hold_sel_q <= sel_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRIP_ARMED: if (en_i && lvl_i[sel_i]) state_d = TRIP_HELD;
            TRIP_HELD:  if (!lvl_i[hold_sel_q])   state_d = TRIP_ARMED;
            default:    state_d = TRIP_ARMED;
        endcase
    end

    always_comb begin
        req_o = (state_q == TRIP_HELD);
    end

    // R7
    arm_trip_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (!req_o && en_i && lvl_i[sel_i]) |=> req_o);

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (req_o && lvl_i[hold_sel_q]) |=> req_o);

    // R9
    no_trip_when_off_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (!req_o && !en_i) |=> !req_o);
endmodule

// File: rtl/bod_monitor.sv
module bod_monitor
    import bod_pkg::*;
#(
    parameter int NLVL     = 4,
    parameter int FILT_LEN = 4
) (
    input  logic            clk,
    input  logic            rst_ni,
    input  logic [NLVL-1:0] irq_below_i,
    input  logic [NLVL-1:0] rst_below_i,
    input  logic [1:0]      reg_addr_i,
    input  logic            reg_we_i,
    input  logic [7:0]      reg_wdata_i,
    output logic [7:0]      reg_rdata_o,
    output logic            irq_o,
    output logic            rst_req_o
);
    localparam int SW = $clog2(NLVL);
    localparam int NIN = 2 * NLVL;

    logic [NIN-1:0]  sync_w, filt_w;
    logic [NLVL-1:0] irq_lvl, rst_lvl;

    logic [SW-1:0] irq_sel_q, rst_sel_q;
    logic          irq_en_q, rst_en_q;
    logic          seen_q;
    logic          irq_live;
    logic          ctrl_wr, stat_clr;

    bod_sync #(.W(NIN)) i_sync (
        .clk     (clk),
        .rst_ni  (rst_ni),
        .async_i ({rst_below_i, irq_below_i}),
        .sync_o  (sync_w)
    );

    bod_filter #(.W(NIN), .FILT_LEN(FILT_LEN)) i_filter (
        .clk    (clk),
        .rst_ni (rst_ni),
        .sync_i (sync_w),
        .filt_o (filt_w)
    );

    assign irq_lvl = filt_w[NLVL-1:0];
    assign rst_lvl = filt_w[NIN-1:NLVL];

    assign ctrl_wr  = reg_we_i && (reg_addr_i == ADDR_CTRL);
    assign stat_clr = reg_we_i && (reg_addr_i == ADDR_STATUS) && reg_wdata_i[STAT_SEEN_BIT];

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            irq_sel_q <= '0;
            irq_en_q  <= 1'b0;
            rst_sel_q <= '0;
            rst_en_q  <= 1'b1;
        end else if (ctrl_wr) begin
            irq_sel_q <= reg_wdata_i[SW-1:0];
            irq_en_q  <= reg_wdata_i[CTRL_IRQ_EN_BIT];
            rst_sel_q <= reg_wdata_i[CTRL_RST_LSB +: SW];
            rst_en_q  <= reg_wdata_i[CTRL_RST_EN_BIT];
        end
    end

    assign irq_live = irq_lvl[irq_sel_q];
    assign irq_o    = irq_en_q && irq_live;

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) seen_q <= 1'b0;
        else         seen_q <= (seen_q && !stat_clr) || irq_live;
    end

    bod_trip_fsm #(.NLVL(NLVL)) i_trip (
        .clk    (clk),
        .rst_ni (rst_ni),
        .en_i   (rst_en_q),
        .sel_i  (rst_sel_q),
        .lvl_i  (rst_lvl),
        .req_o  (rst_req_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            ADDR_CTRL: begin
                reg_rdata_o[SW-1:0]                 = irq_sel_q;
                reg_rdata_o[CTRL_IRQ_EN_BIT]        = irq_en_q;
                reg_rdata_o[CTRL_RST_LSB +: SW]     = rst_sel_q;
                reg_rdata_o[CTRL_RST_EN_BIT]        = rst_en_q;
            end
            ADDR_STATUS: begin
                reg_rdata_o[STAT_LIVE_BIT] = irq_live;
                reg_rdata_o[STAT_SEEN_BIT] = seen_q;
                reg_rdata_o[STAT_RSTQ_BIT] = rst_req_o;
            end
            default: reg_rdata_o = '0;
        endcase
    end

    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        irq_o |-> (irq_en_q && irq_lvl[irq_sel_q]));

    // R6
    seen_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        irq_live |=> seen_q);

    // R6
    seen_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (seen_q && !stat_clr) |=> seen_q);
endmodule

// File: tb/test_bod_monitor.sv
module test_bod_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int NLVL = 4;
    localparam int FILT = 4;

    logic            clk = 1'b0;
    logic            rst_ni = 1'b0;
    logic [NLVL-1:0] irq_b = '0;
    logic [NLVL-1:0] rst_b = '0;
    logic [1:0]      addr = '0;
    logic            we = 1'b0;
    logic [7:0]      wdata = '0;
    logic [7:0]      rdata;
    logic            irq_o, rst_req_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bod_monitor #(.NLVL(NLVL), .FILT_LEN(FILT)) i_bod_monitor (
        .clk         (clk),
        .rst_ni      (rst_ni),
        .irq_below_i (irq_b),
        .rst_below_i (rst_b),
        .reg_addr_i  (addr),
        .reg_we_i    (we),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq_o),
        .rst_req_o   (rst_req_o)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        tick();
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        logic [7:0] v;
        rst_ni = 1'b0;
        tick(3);
        rst_ni = 1'b1;
        tick();

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 8'h80);
        rd(2'd1, v); chk("R1 status", v, 8'h00);
        chk("R1 irq", irq_o, 0);
        chk("R1 rstreq", rst_req_o, 0);

        // R2 field layout
        wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2 ones", v, 8'hBB);
        wr(2'd0, 8'h00); rd(2'd0, v); chk("R2 zeros", v, 8'h00);
        rd(2'd2, v); chk("R2 unused addr", v, 0);
        rd(2'd3, v); chk("R2 unused addr", v, 0);

        // R3 exact latency: enabled, level 0
        wr(2'd0, 8'h08);
        irq_b = 4'b0001;
        tick(FILT + 1);
        chk("R3 before latency", irq_o, 0);
        tick();
        chk("R3 at latency", irq_o, 1);
        irq_b = '0;
        tick(FILT + 4);
        wr(2'd1, 8'h02);

        // R3 pulse width sweep across the filter length
        for (int w = 1; w <= FILT + 1; w++) begin
            irq_b = 4'b0001;
            tick(w);
            irq_b = '0;
            tick(FILT + 4);
            rd(2'd1, v);
            chk($sformatf("R3 pulse w=%0d", w), v[1], (w >= FILT) ? 1 : 0);
            wr(2'd1, 8'h02);
        end

        // R4 R5 R6 sweep over select, flag and enable
        for (int en = 0; en < 2; en++) begin
            for (int sel = 0; sel < NLVL; sel++) begin
                for (int fl = 0; fl < NLVL; fl++) begin
                    wr(2'd0, 8'(8'h80 | (en << 3) | sel));
                    irq_b = 4'(1 << fl);
                    tick(FILT + 4);
                    chk($sformatf("R4 en=%0d sel=%0d fl=%0d", en, sel, fl),
                        irq_o, (en == 1 && sel == fl) ? 1 : 0);
                    rd(2'd1, v);
                    chk("R5 live", v[0], (sel == fl) ? 1 : 0);
                    chk("R6 seen", v[1], (sel == fl) ? 1 : 0);
                    irq_b = '0;
                    tick(FILT + 4);
                    wr(2'd1, 8'h02);
                end
            end
        end

        // R6 write of 0 keeps the latched bit, write of 1 clears it
        wr(2'd0, 8'h80);
        irq_b = 4'b0001;
        tick(FILT + 4);
        irq_b = '0;
        tick(FILT + 4);
        wr(2'd1, 8'h00); rd(2'd1, v); chk("R6 write0 keeps", v[1], 1);
        wr(2'd1, 8'h02); rd(2'd1, v); chk("R6 write1 clears", v[1], 0);

        // R7 sweep of reset select against flag
        for (int sel = 0; sel < NLVL; sel++) begin
            for (int fl = 0; fl < NLVL; fl++) begin
                wr(2'd0, 8'(8'h80 | (sel << 4)));
                rst_b = 4'(1 << fl);
                tick(FILT + 5);
                chk($sformatf("R7 sel=%0d fl=%0d", sel, fl), rst_req_o, (sel == fl) ? 1 : 0);
                rst_b = '0;
                tick(FILT + 5);
                chk("R7 release", rst_req_o, 0);
            end
        end

        // R7 exact latency at level 1
        wr(2'd0, 8'h90);
        rst_b = 4'b0010;
        tick(FILT + 2);
        chk("R7 one clock after filter", rst_req_o, 0);
        tick();
        chk("R7 rises", rst_req_o, 1);
        rst_b = '0;
        tick(FILT + 5);

        // R8 sticky against enable and select changes
        wr(2'd0, 8'hA0);
        rst_b = 4'b0100;
        tick(FILT + 5);
        chk("R8 tripped", rst_req_o, 1);
        wr(2'd0, 8'h00);
        tick(2);
        chk("R8 held after disable", rst_req_o, 1);
        rd(2'd1, v); chk("R9 status bit2", v[2], 1);
        rst_b = '0;
        tick(FILT + 2);
        chk("R8 held until filter", rst_req_o, 1);
        tick();
        chk("R8 released", rst_req_o, 0);

        // R9 disabled path never requests
        wr(2'd0, 8'h00);
        rst_b = '1;
        tick(FILT + 6);
        chk("R9 disabled", rst_req_o, 0);
        rd(2'd1, v); chk("R9 status bit2 low", v[2], 0);
        rst_b = '0;
        tick(FILT + 5);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule